// File: doc/BRIEF.md
# Supply Sequencing AND-Term Array

The block turns a vector of supply-status flags into nine sequencing enables. Each enable has its own AND term. The term is the AND of any chosen subset of the status inputs, together with any chosen subset of the other enables as they appear on the output pins. A term with nothing selected reads as 1. Each term then passes through its own edge-delay controller. The controller holds a rising edge for one programmed number of millisecond ticks and a falling edge for another. A level that returns before its count completes is discarded, and the count starts again from zero. After the delay stage, a per-enable override can pin the output low or high, for example to take supplies down in a controlled order from software.

Software writes the configuration through a simple write strobe. Each write carries an address made of a channel index and a field selector, plus a 16-bit data word. An internal divider makes the 1 ms tick from the system clock; `TICK_DIV` sets the number of clock cycles per tick. Delays range from 0 to 500 ticks, and a written value above 500 is clamped to 500. To build a strict power-up order, select enable k-1 as a feedback term of enable k. Each stage then waits for the previous stage's delayed output, so the stage delays add up along the chain.

Each edge-delay controller is a four-state machine:
- IDLE_LOW: the output is low and the term is low.
- ARM_RISE: the term is high and the rising delay is being counted.
- HOLD_HIGH: the output is high and the term is high.
- ARM_FALL: the term is low and the falling delay is being counted.

Transitions:
- IDLE_LOW goes to ARM_RISE when the term goes high and the rising delay is non-zero. It goes straight to HOLD_HIGH when the rising delay is zero.
- ARM_RISE goes back to IDLE_LOW when the term drops. It goes to HOLD_HIGH on the tick that completes the count.
- HOLD_HIGH goes to ARM_FALL or to IDLE_LOW in the same way as IDLE_LOW, using the falling delay.
- ARM_FALL goes back to HOLD_HIGH when the term returns high. It goes to IDLE_LOW when the count completes.

The output is high in HOLD_HIGH and in ARM_FALL.

Top module: `seq_and_array`

## Requirements
- R1: During and after reset, every output is low. After reset, every mask and delay is zero and every override field holds 2'b10 (forced low), so all outputs stay low until software releases them.
- R2: The term of channel k is the AND of the `status_in` bits selected by its input mask. A bit set to 1 in the mask selects the matching input. A term with no bits selected evaluates to 1.
- R3: Bit j of channel k's feedback mask adds output pin `seq_out[j]` as a term. This pin is taken after the delay stage and after the override. With zero delays, a three-stage chain sets its outputs on the 1st, 2nd and 3rd clock after the input change.
- R4: Bit k of channel k's feedback mask is always stored as 0, whatever value is written, so a channel never depends on itself.
- R5: With a zero delay, the output takes the new term level on the first clock edge after the term changes.
- R6: With a rising delay of N > 0, the output rises only after the term has stayed high for N ticks. It is still low (N-1)*TICK_DIV+1 cycles after the change and high by N*TICK_DIV+2 cycles after it.
- R7: The falling delay behaves the same way for a term that goes low, with the same timing bounds.
- R8: If the term returns to the current output level before the count completes, the output does not change, and the next edge counts from zero.
- R9: A delay write above 500 is stored as 500.
- R10: Override field encodings: 2'b10 forces the output low, 2'b11 forces it high, and 2'b00 or 2'b01 pass the delayed level. The delay machine keeps running underneath, so releasing a force shows its current level on the next clock.
- R11: `cfg_addr[6:3]` selects the channel (0 to 8). `cfg_addr[2:0]` selects the field: 0 is the input mask, 1 the feedback mask, 2 the rising delay, 3 the falling delay, and 4 the override (data bits 1:0). A write to a channel of 9 or more, or to a field of 5 or more, changes nothing.
- R12: The tick divider sends one tick every TICK_DIV clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| status_in | input | NUM_IN | Supply-status flags, active high |
| cfg_we | input | 1 | Configuration write strobe, one cycle per write |
| cfg_addr | input | 7 | {channel[3:0], field[2:0]} |
| cfg_wdata | input | 16 | Configuration write data |
| seq_out | output | NUM_OUT | Sequencing enables, after the delay stage and the override |

## Verification
The checker watches several behaviours on every clock:
- A forced-low or forced-high override always wins at the pin.
- The stored self-feedback bit is never set.
- No stored delay exceeds the clamp.
- The delayed level moves only toward the level its term had on the previous clock.
- Ticks arrive exactly TICK_DIV cycles apart.

Only the bench scenarios can show the rest: the exact latency of a zero-delay chain, the lower and upper bounds on an N-tick edge, the restart of a count after a short pulse, and the silence of writes to addresses that are not decoded.

// File: rtl/seq_pkg.sv
package seq_pkg;
    localparam int DLY_W   = 9;
    localparam int DLY_CAP = 500;
    localparam int IDX_W   = 4;
    localparam int FIELD_W = 3;
    localparam int ADDR_W  = IDX_W + FIELD_W;
    localparam int CFG_DW  = 16;

    typedef enum logic [1:0] {
        OVR_FOLLOW     = 2'b00,
        OVR_FOLLOW_ALT = 2'b01,
        OVR_LOW        = 2'b10,
        OVR_HIGH       = 2'b11
    } ovr_e;

    typedef enum logic [FIELD_W-1:0] {
        FLD_IN_MASK = 3'd0,
        FLD_FB_MASK = 3'd1,
        FLD_RISE    = 3'd2,
        FLD_FALL    = 3'd3,
        FLD_OVR     = 3'd4
    } field_e;

    typedef enum logic [1:0] {
        IDLE_LOW  = 2'd0,
        ARM_RISE  = 2'd1,
        HOLD_HIGH = 2'd2,
        ARM_FALL  = 2'd3
    } dstate_e;
endpackage

// File: rtl/seq_tick_gen.sv
module seq_tick_gen #(
    parameter int TICK_DIV = 100000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == CW'(TICK_DIV - 1)) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/seq_cfg_regs.sv
module seq_cfg_regs import seq_pkg::*; #(
    parameter int NUM_OUT = 9,
    parameter int NUM_IN  = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_we,
    input  logic [ADDR_W-1:0]                 cfg_addr,
    input  logic [CFG_DW-1:0]                 cfg_wdata,
    output logic [NUM_OUT-1:0][NUM_IN-1:0]    in_mask,
    output logic [NUM_OUT-1:0][NUM_OUT-1:0]   fb_mask,
    output logic [NUM_OUT-1:0][DLY_W-1:0]     rise_dly,
    output logic [NUM_OUT-1:0][DLY_W-1:0]     fall_dly,
    output logic [NUM_OUT-1:0][1:0]           ovr
);
    logic [IDX_W-1:0]   wr_idx;
    logic [FIELD_W-1:0] wr_fld;
    logic [DLY_W-1:0]   wr_dly;

    assign wr_idx = cfg_addr[ADDR_W-1:FIELD_W];
    assign wr_fld = cfg_addr[FIELD_W-1:0];

    // Clamp to the longest legal delay
    always_comb begin
        if (cfg_wdata > CFG_DW'(DLY_CAP)) wr_dly = DLY_W'(DLY_CAP);
        else                               wr_dly = cfg_wdata[DLY_W-1:0];
    end

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_chan
        localparam logic [NUM_OUT-1:0] SELF_BIT = NUM_OUT'(1) << g;

        logic [NUM_IN-1:0]  in_r;
        logic [NUM_OUT-1:0] fb_r;
        logic [DLY_W-1:0]   rise_r;
        logic [DLY_W-1:0]   fall_r;
        logic [1:0]         ovr_r;
        logic               hit;

        assign hit = cfg_we && (wr_idx == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                in_r   <= '0;
                fb_r   <= '0;
                rise_r <= '0;
                fall_r <= '0;
                ovr_r  <= OVR_LOW;
            end else if (hit) begin
                case (wr_fld)
                    FLD_IN_MASK: in_r   <= cfg_wdata[NUM_IN-1:0];
                    FLD_FB_MASK: fb_r   <= cfg_wdata[NUM_OUT-1:0] & ~SELF_BIT;
                    FLD_RISE:    rise_r <= wr_dly;
                    FLD_FALL:    fall_r <= wr_dly;
                    FLD_OVR:     ovr_r  <= cfg_wdata[1:0];
                    default:     ;
                endcase
            end
        end

        assign in_mask[g]  = in_r;
        assign fb_mask[g]  = fb_r;
        assign rise_dly[g] = rise_r;
        assign fall_dly[g] = fall_r;
        assign ovr[g]      = ovr_r;
    end
endmodule

// File: rtl/seq_macrocell.sv
module seq_macrocell #(
    parameter int NUM_OUT = 9,
    parameter int NUM_IN  = 8
) (
    input  logic [NUM_IN-1:0]  status_in,
    input  logic [NUM_IN-1:0]  in_mask,
    input  logic [NUM_OUT-1:0] fb_pins,
    input  logic [NUM_OUT-1:0] fb_mask,
    output logic               term
);
    logic in_ok;
    logic fb_ok;

    // Unselected terms read as 1, so an empty mask yields 1
    assign in_ok = &(status_in | ~in_mask);
    assign fb_ok = &(fb_pins | ~fb_mask);
    assign term  = in_ok & fb_ok;
endmodule

// File: rtl/seq_edge_delay.sv
module seq_edge_delay import seq_pkg::*; (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             term,
    input  logic [DLY_W-1:0] rise_dly,
    input  logic [DLY_W-1:0] fall_dly,
    output logic             dly_q
);
    dstate_e          state, state_n;
    logic [DLY_W-1:0] cnt, cnt_n;
    logic [DLY_W:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt} + 1'b1;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= IDLE_LOW;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    // Next-state and counter
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        unique case (state)
            IDLE_LOW: begin
                if (term) begin
                    cnt_n   = '0;
                    state_n = (rise_dly == '0) ? HOLD_HIGH : ARM_RISE;
                end
            end
            ARM_RISE: begin
                if (!term) begin
                    state_n = IDLE_LOW;
                    cnt_n   = '0;
                end else if (rise_dly == '0) begin
                    state_n = HOLD_HIGH;
                    cnt_n   = '0;
                end else if (tick) begin
                    if (cnt_inc >= {1'b0, rise_dly}) begin
                        state_n = HOLD_HIGH;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt_inc[DLY_W-1:0];
                    end
                end
            end
            HOLD_HIGH: begin
                if (!term) begin
                    cnt_n   = '0;
                    state_n = (fall_dly == '0) ? IDLE_LOW : ARM_FALL;
                end
            end
            ARM_FALL: begin
                if (term) begin
                    state_n = HOLD_HIGH;
                    cnt_n   = '0;
                end else if (fall_dly == '0) begin
                    state_n = IDLE_LOW;
                    cnt_n   = '0;
                end else if (tick) begin
                    if (cnt_inc >= {1'b0, fall_dly}) begin
                        state_n = IDLE_LOW;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt_inc[DLY_W-1:0];
                    end
                end
            end
            default: begin
                state_n = IDLE_LOW;
                cnt_n   = '0;
            end
        endcase
    end

    // Output decode
    always_comb begin
        unique case (state)
            HOLD_HIGH, ARM_FALL: dly_q = 1'b1;
            default:             dly_q = 1'b0;
        endcase
    end
endmodule

// File: rtl/seq_and_array.sv
module seq_and_array import seq_pkg::*; #(
    parameter int NUM_OUT  = 9,
    parameter int NUM_IN   = 8,
    parameter int TICK_DIV = 100000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_IN-1:0]   status_in,
    input  logic                cfg_we,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [CFG_DW-1:0]   cfg_wdata,
    output logic [NUM_OUT-1:0]  seq_out
);
    logic                            tick;
    logic [NUM_OUT-1:0][NUM_IN-1:0]  in_mask;
    logic [NUM_OUT-1:0][NUM_OUT-1:0] fb_mask;
    logic [NUM_OUT-1:0][DLY_W-1:0]   rise_dly;
    logic [NUM_OUT-1:0][DLY_W-1:0]   fall_dly;
    logic [NUM_OUT-1:0][1:0]         ovr;
    logic [NUM_OUT-1:0]              term;
    logic [NUM_OUT-1:0]              dly_q;

    seq_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    seq_cfg_regs #(.NUM_OUT(NUM_OUT), .NUM_IN(NUM_IN)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .in_mask   (in_mask),
        .fb_mask   (fb_mask),
        .rise_dly  (rise_dly),
        .fall_dly  (fall_dly),
        .ovr       (ovr)
    );

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_cell
        logic pin;

        seq_macrocell #(.NUM_OUT(NUM_OUT), .NUM_IN(NUM_IN)) u_and (
            .status_in (status_in),
            .in_mask   (in_mask[g]),
            .fb_pins   (seq_out),
            .fb_mask   (fb_mask[g]),
            .term      (term[g])
        );

        seq_edge_delay u_dly (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .term     (term[g]),
            .rise_dly (rise_dly[g]),
            .fall_dly (fall_dly[g]),
            .dly_q    (dly_q[g])
        );

        // Override after the delay stage
        always_comb begin
            unique case (ovr_e'(ovr[g]))
                OVR_LOW:  pin = 1'b0;
                OVR_HIGH: pin = 1'b1;
                default:  pin = dly_q[g];
            endcase
        end

        assign seq_out[g] = pin;
    end
endmodule

// File: rtl/seq_and_array_chk.sv
module seq_and_array_chk import seq_pkg::*; #(
    parameter int NUM_OUT  = 9,
    parameter int NUM_IN   = 8,
    parameter int TICK_DIV = 100000
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [NUM_OUT-1:0]              seq_out,
    input logic [NUM_OUT-1:0]              term,
    input logic [NUM_OUT-1:0]              dly_q,
    input logic [NUM_OUT-1:0][NUM_OUT-1:0] fb_mask,
    input logic [NUM_OUT-1:0][1:0]         ovr,
    input logic [NUM_OUT-1:0][DLY_W-1:0]   rise_dly,
    input logic [NUM_OUT-1:0][DLY_W-1:0]   fall_dly,
    input logic                            tick
);
    logic [31:0] gap;
    logic        seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (tick) begin
            gap  <= '0;
            seen <= 1'b1;
        end else begin
            gap <= gap + 1'b1;
        end
    end

    assert_reset_low_R1: assert property (@(posedge clk)
        !rst_n |-> seq_out == '0);

    assert_tick_period_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && seen) |-> gap == 32'(TICK_DIV - 1));

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_chk
        assert_self_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
            fb_mask[g][g] == 1'b0);

        assert_delay_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (rise_dly[g] <= DLY_W'(DLY_CAP)) && (fall_dly[g] <= DLY_W'(DLY_CAP)));

        assert_force_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (ovr[g] == OVR_LOW) |-> !seq_out[g]);

        assert_force_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (ovr[g] == OVR_HIGH) |-> seq_out[g]);

        assert_edge_toward_term_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(dly_q[g]) |-> ($past(term[g]) == dly_q[g]));
    end
endmodule

bind seq_and_array seq_and_array_chk #(
    .NUM_OUT  (NUM_OUT),
    .NUM_IN   (NUM_IN),
    .TICK_DIV (TICK_DIV)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .seq_out  (seq_out),
    .term     (term),
    .dly_q    (dly_q),
    .fb_mask  (fb_mask),
    .ovr      (ovr),
    .rise_dly (rise_dly),
    .fall_dly (fall_dly),
    .tick     (tick)
);

// File: tb/sim_seq_and_array.sv
module sim_seq_and_array;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 4;
    localparam int NOUT       = 9;
    localparam int NIN        = 8;

    // {status_in[7:0], expected seq_out[8:0]} with zero delays
    localparam logic [16:0] VECS [8] = '{
        {8'h00, 9'h000},
        {8'h03, 9'h001},
        {8'h07, 9'h007},
        {8'h04, 9'h000},
        {8'hF0, 9'h1F8},
        {8'hF7, 9'h1FF},
        {8'hFB, 9'h1F9},
        {8'h70, 9'h000}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NIN-1:0]  status_in = '0;
    logic            cfg_we = 1'b0;
    logic [6:0]      cfg_addr = '0;
    logic [15:0]     cfg_wdata = '0;
    logic [NOUT-1:0] seq_out;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seq_and_array #(.NUM_OUT(NOUT), .NUM_IN(NIN), .TICK_DIV(DIV)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .status_in (status_in),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .seq_out   (seq_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int idx, input int fld, input int data);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = {4'(idx), 3'(fld)};
        cfg_wdata = 16'(data);
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic drive(input logic [NIN-1:0] v);
        @(negedge clk);
        status_in = v;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R1 reset state
        wait_cyc(3);
        chk("R1 outputs low in reset", 32'(seq_out), 32'h0);
        rst_n = 1'b1;
        wait_cyc(5);
        chk("R1 outputs low after reset, overrides forced low", 32'(seq_out), 32'h0);

        // Table configuration (R11 field map)
        wr(0, 0, 8'h03);
        wr(1, 0, 8'h04);
        wr(1, 1, 9'h001);
        wr(2, 1, 9'h002);
        for (int i = 3; i < NOUT; i++) wr(i, 0, 8'hF0);
        for (int i = 0; i < NOUT; i++) wr(i, 4, 0);

        // R2 / R3 vector walk
        for (int v = 0; v < 8; v++) begin
            drive(VECS[v][16:9]);
            wait_cyc(6);
            chk($sformatf("R2 R3 vector %0d", v), 32'(seq_out), 32'(VECS[v][8:0]));
        end

        // R5 / R3 zero-delay chain latency (from status 0x70, outputs 0)
        drive(8'h07);
        wait_cyc(1);
        chk("R5 first stage one clock", 32'(seq_out[2:0]), 32'h1);
        wait_cyc(1);
        chk("R3 second stage two clocks", 32'(seq_out[2:0]), 32'h3);
        wait_cyc(1);
        chk("R3 third stage three clocks", 32'(seq_out[2:0]), 32'h7);

        // R4 self feedback bit ignored
        drive(8'h00);
        wait_cyc(4);
        wr(2, 1, 9'h004);
        wait_cyc(4);
        chk("R4 self bit dropped, empty term is 1", 32'(seq_out[2]), 32'h1);
        wr(2, 1, 9'h002);
        wait_cyc(4);
        chk("R3 feedback restored, channel 2 low", 32'(seq_out[2]), 32'h0);

        // Delays on channel 0
        wr(0, 2, 5);
        wr(0, 3, 3);
        // R8 short rising pulse filtered
        drive(8'h03);
        wait_cyc(DIV - 1);
        drive(8'h00);
        wait_cyc(30);
        chk("R8 short rise pulse filtered", 32'(seq_out[0]), 32'h0);

        // R6 rising delay window
        drive(8'h03);
        wait_cyc(4 * DIV + 1);
        chk("R6 still low before 5 ticks", 32'(seq_out[0]), 32'h0);
        wait_cyc(DIV + 1);
        chk("R6 high after 5 ticks", 32'(seq_out[0]), 32'h1);

        // R8 short falling pulse filtered
        drive(8'h00);
        wait_cyc(DIV - 1);
        drive(8'h03);
        wait_cyc(30);
        chk("R8 short fall pulse filtered", 32'(seq_out[0]), 32'h1);

        // R7 falling delay window
        drive(8'h00);
        wait_cyc(2 * DIV + 1);
        chk("R7 still high before 3 ticks", 32'(seq_out[0]), 32'h1);
        wait_cyc(DIV + 1);
        chk("R7 low after 3 ticks", 32'(seq_out[0]), 32'h0);

        // R10 override
        wr(3, 4, 2'b11);
        wait_cyc(1);
        chk("R10 force high over low logic", 32'(seq_out[3]), 32'h1);
        drive(8'hF0);
        wr(3, 4, 2'b10);
        wait_cyc(1);
        chk("R10 force low over high logic", 32'(seq_out[3]), 32'h0);
        chk("R10 neighbour unaffected", 32'(seq_out[4]), 32'h1);
        wr(3, 4, 2'b01);
        chk("R10 release shows running level", 32'(seq_out[3]), 32'h1);

        // R11 undecoded addresses ignored
        wr(12, 4, 2'b10);
        wr(3, 5, 2'b10);
        wr(3, 7, 2'b10);
        wait_cyc(2);
        chk("R11 bad index or field ignored", 32'(seq_out[8:3]), 32'h3F);

        // R9 clamp of rising delay on channel 4
        wr(4, 2, 600);
        drive(8'h00);
        wait_cyc(4);
        chk("R2 channel 4 low with input cleared", 32'(seq_out[4]), 32'h0);
        drive(8'hF0);
        wait_cyc(2);
        chk("R5 channel 5 immediate", 32'(seq_out[5]), 32'h1);
        wait_cyc(499 * DIV - 1);
        chk("R9 clamped delay still low", 32'(seq_out[4]), 32'h0);
        wait_cyc(DIV + 1);
        chk("R9 R12 high at 500 ticks", 32'(seq_out[4]), 32'h1);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule